// File: doc/BRIEF.md
# PC-relative address generation unit

This unit turns a PC-relative address-formation instruction into its result in one registered step. It takes a 32-bit instruction container, a format select, the current program counter, a condition-pass flag from the flag logic and a valid strobe. From these it recognises one of five encodings. It picks the destination register index and the direction (add or subtract), expands the immediate, and produces the word-aligned PC plus or minus that immediate.

Two instruction formats are accepted. The fixed format is one conditional 32-bit word. The compact format is either one halfword or a pair of halfwords. In both compact cases the first halfword is presented in `insn_i[31:16]`. When the destination is register 15 in the fixed format, the result is flagged as a PC write, which the core treats as an interworking branch. In the two-halfword compact form, a destination of 15 is reported as unpredictable. The register file, condition evaluation and fetch sit outside the unit.

Top module: `pcrel_addr_unit`

## Requirements
- R1: With `fmt_sel_i`=0, `insn_i[31:28]`≠4'hF and `insn_i[27:16]`=12'h28F, the result is ({pc_i[31:2],2'b00}) + I. Here I is `{24'b0,insn_i[7:0]}` rotated right by 2×`insn_i[11:8]`, and the destination is `insn_i[15:12]`.
- R2: With `fmt_sel_i`=0, `insn_i[31:28]`≠4'hF and `insn_i[27:16]`=12'h24F, the result is the aligned PC minus the same rotated immediate, wrapping modulo 2^32.
- R3: A fixed-format word whose `insn_i[31:28]` is 4'hF is not recognised and raises `decode_miss_o`.
- R4: With `fmt_sel_i`=1 and `insn_i[31:27]`=5'b10100, the instruction is the one-halfword form. The result is the aligned PC plus `insn_i[23:16]`×4, the destination is `{1'b0,insn_i[26:24]}`, and `insn_i[15:0]` is ignored.
- R5: With `fmt_sel_i`=1, `insn_i[31:27]`=5'b11110 and `insn_i[15]`=0, the instruction is the two-halfword form. `insn_i[25:16]`=10'b1000001111 adds and 10'b1010101111 subtracts. The immediate is the zero-extended `{insn_i[26],insn_i[14:12],insn_i[7:0]}`, and the destination is `insn_i[11:8]`. If `insn_i[15]`=1, the word is not recognised.
- R6: `pc_write_o` is raised, together with `out_valid_o`, only for a fixed-format result whose destination is 15. It never rises for the compact format.
- R7: A two-halfword compact instruction with destination 15 raises `unpred_o` and produces no result. Destination 13 is handled like any other register.
- R8: When `cond_pass_i` is low, neither `out_valid_o` nor `pc_write_o` is raised. `decode_miss_o` and `unpred_o` are still reported.
- R9: An instruction matching none of the five encodings raises `decode_miss_o` and produces no result.
- R10: All outputs appear exactly one clock after the `in_valid_i` cycle. A clock without `in_valid_i` leaves all four flags low on the next cycle.
- R11: While `rst_ni` is low, and for the synchronising cycles after it rises, all four flag outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid_i | input | 1 | Instruction presented this cycle |
| fmt_sel_i | input | 1 | 0 = fixed 32-bit format, 1 = compact format |
| insn_i | input | 32 | Instruction container (compact: first halfword in [31:16]) |
| pc_i | input | 32 | Current program counter |
| cond_pass_i | input | 1 | Condition evaluated true |
| out_valid_o | output | 1 | Result and destination are valid |
| result_o | output | 32 | Computed address |
| rd_idx_o | output | 4 | Destination register index |
| pc_write_o | output | 1 | Result is written to the PC (branch) |
| unpred_o | output | 1 | Two-halfword form named register 15 |
| decode_miss_o | output | 1 | Instruction matched no encoding |

## Verification
The bench aims at the rotated-immediate expansion with rotation amounts of zero and of large values. A design that rotated by the 4-bit field itself, rather than by twice that field, would give results wrong by a power of two. Subtraction from a small PC checks wrap-around, and PC values with the low bits set expose a missing alignment. Register 15 is tried in every format: a PC write leaking into the compact format, or a missing unpredictable flag, shows up on the flags. Register 13 in the two-halfword form must not be reported. Words with condition 4'hF, and compact pairs with second-halfword bit 15 set, must produce a decode miss rather than a result. A suppressed condition must clear both `out_valid_o` and `pc_write_o`.

// File: rtl/pcrel_pkg.sv
package pcrel_pkg;

  localparam int unsigned XLEN      = 32;
  localparam int unsigned REG_W     = 4;
  localparam int unsigned IMM_FLD_W = 12;

  // Fixed-format opcode field values (bits [27:16]) and reserved condition
  localparam logic [11:0] FIX_OP_ADD = 12'h28F;
  localparam logic [11:0] FIX_OP_SUB = 12'h24F;
  localparam logic [3:0]  COND_RSVD  = 4'hF;

  // Compact-format leading bits
  localparam logic [4:0]  HALF_LEAD     = 5'b10100;
  localparam logic [4:0]  PAIR_LEAD     = 5'b11110;
  localparam logic [9:0]  PAIR_TAIL_ADD = 10'b10_0000_1111;
  localparam logic [9:0]  PAIR_TAIL_SUB = 10'b10_1010_1111;

  localparam logic [REG_W-1:0] PC_REG = 4'd15;

  typedef enum logic [1:0] {
    ENC_NONE   = 2'd0,
    ENC_WIDE   = 2'd1,  // fixed word, rotated immediate
    ENC_HALF   = 2'd2,  // one halfword, scaled immediate
    ENC_PAIR   = 2'd3   // two halfwords, plain immediate
  } enc_kind_e;

  typedef struct packed {
    enc_kind_e              kind;
    logic                   is_sub;
    logic [REG_W-1:0]       rd;
    logic [IMM_FLD_W-1:0]   imm_field;
  } dec_t;

endpackage

// File: rtl/pcrel_decode.sv
module pcrel_decode
  import pcrel_pkg::*;
#(
  parameter int unsigned W = XLEN
) (
  input  logic         fmt_compact_i,
  input  logic [W-1:0] insn_i,
  output dec_t         dec_o
);

  logic [3:0]  cond_f;
  logic [11:0] op_f;
  logic        wide_add, wide_sub;
  logic        half_hit;
  logic        pair_lead_ok, pair_add, pair_sub;

  always_comb begin
    cond_f   = insn_i[31:28];
    op_f     = insn_i[27:16];
    wide_add = !fmt_compact_i && (cond_f != COND_RSVD) && (op_f == FIX_OP_ADD);
    wide_sub = !fmt_compact_i && (cond_f != COND_RSVD) && (op_f == FIX_OP_SUB);

    half_hit = fmt_compact_i && (insn_i[31:27] == HALF_LEAD);

    pair_lead_ok = fmt_compact_i && (insn_i[31:27] == PAIR_LEAD) && !insn_i[15];
    pair_add     = pair_lead_ok && (insn_i[25:16] == PAIR_TAIL_ADD);
    pair_sub     = pair_lead_ok && (insn_i[25:16] == PAIR_TAIL_SUB);
  end

  always_comb begin
    dec_o = '{kind: ENC_NONE, is_sub: 1'b0, rd: '0, imm_field: '0};
    if (wide_add || wide_sub) begin
      dec_o.kind      = ENC_WIDE;
      dec_o.is_sub    = wide_sub;
      dec_o.rd        = insn_i[15:12];
      dec_o.imm_field = insn_i[11:0];
    end else if (half_hit) begin
      dec_o.kind      = ENC_HALF;
      dec_o.is_sub    = 1'b0;
      dec_o.rd        = {1'b0, insn_i[26:24]};
      dec_o.imm_field = {4'b0000, insn_i[23:16]};
    end else if (pair_add || pair_sub) begin
      dec_o.kind      = ENC_PAIR;
      dec_o.is_sub    = pair_sub;
      dec_o.rd        = insn_i[11:8];
      dec_o.imm_field = {insn_i[26], insn_i[14:12], insn_i[7:0]};
    end
  end

endmodule

// File: rtl/pcrel_imm_expand.sv
module pcrel_imm_expand
  import pcrel_pkg::*;
#(
  parameter int unsigned W          = XLEN,
  parameter int unsigned HALF_SHIFT = 2
) (
  input  enc_kind_e             kind_i,
  input  logic [IMM_FLD_W-1:0]  field_i,
  output logic [W-1:0]          imm_o
);

  localparam int unsigned STAGES = $clog2(W);

  logic [STAGES-1:0] rot_amt;
  logic [W-1:0]      stage [0:STAGES];

  // Rotation amount is twice the 4-bit rotate field
  always_comb begin
    rot_amt    = '0;
    rot_amt[4:1] = field_i[11:8];
    stage[0]   = {{(W-8){1'b0}}, field_i[7:0]};
  end

  for (genvar s = 0; s < STAGES; s++) begin : g_barrel
    localparam int unsigned K = 1 << s;
    always_comb begin
      if (rot_amt[s]) stage[s+1] = {stage[s][K-1:0], stage[s][W-1:K]};
      else            stage[s+1] = stage[s];
    end
  end

  always_comb begin
    unique case (kind_i)
      ENC_WIDE: imm_o = stage[STAGES];
      ENC_HALF: imm_o = {{(W-8-HALF_SHIFT){1'b0}}, field_i[7:0], {HALF_SHIFT{1'b0}}};
      ENC_PAIR: imm_o = {{(W-IMM_FLD_W){1'b0}}, field_i};
      default:  imm_o = '0;
    endcase
  end

endmodule

// File: rtl/pcrel_addsub.sv
module pcrel_addsub
  import pcrel_pkg::*;
#(
  parameter int unsigned W          = XLEN,
  parameter int unsigned ALIGN_BITS = 2
) (
  input  logic [W-1:0] pc_i,
  input  logic [W-1:0] imm_i,
  input  logic         is_sub_i,
  output logic [W-1:0] sum_o
);

  localparam logic [W-1:0] ALIGN_MASK = {W{1'b1}} << ALIGN_BITS;

  logic [W-1:0] base;

  always_comb begin
    base  = pc_i & ALIGN_MASK;
    sum_o = is_sub_i ? (base - imm_i) : (base + imm_i);
  end

endmodule

// File: rtl/pcrel_addr_unit.sv
module pcrel_addr_unit
  import pcrel_pkg::*;
#(
  parameter int unsigned W          = XLEN,
  parameter int unsigned ALIGN_BITS = 2,
  parameter int unsigned SYNC_DEPTH = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_valid_i,
  input  logic             fmt_sel_i,
  input  logic [W-1:0]     insn_i,
  input  logic [W-1:0]     pc_i,
  input  logic             cond_pass_i,
  output logic             out_valid_o,
  output logic [W-1:0]     result_o,
  output logic [REG_W-1:0] rd_idx_o,
  output logic             pc_write_o,
  output logic             unpred_o,
  output logic             decode_miss_o
);

  // Reset: asserted asynchronously, released through a short synchroniser
  logic [SYNC_DEPTH-1:0] rst_sync_q;
  logic                  rst_n_int;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= '0;
    else         rst_sync_q <= {rst_sync_q[SYNC_DEPTH-2:0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[SYNC_DEPTH-1];

  // Datapath
  dec_t         dec;
  logic [W-1:0] imm32;
  logic [W-1:0] sum;

  pcrel_decode #(.W(W)) u_decode (
    .fmt_compact_i (fmt_sel_i),
    .insn_i        (insn_i),
    .dec_o         (dec)
  );

  pcrel_imm_expand #(.W(W), .HALF_SHIFT(2)) u_imm (
    .kind_i  (dec.kind),
    .field_i (dec.imm_field),
    .imm_o   (imm32)
  );

  pcrel_addsub #(.W(W), .ALIGN_BITS(ALIGN_BITS)) u_addsub (
    .pc_i     (pc_i),
    .imm_i    (imm32),
    .is_sub_i (dec.is_sub),
    .sum_o    (sum)
  );

  // Next-state
  logic hit;
  logic valid_d, pcw_d, unpred_d, miss_d;
  logic data_en;

  always_comb begin
    hit      = (dec.kind != ENC_NONE);
    unpred_d = in_valid_i && (dec.kind == ENC_PAIR) && (dec.rd == PC_REG);
    miss_d   = in_valid_i && !hit;
    valid_d  = in_valid_i && hit && cond_pass_i && !unpred_d;
    pcw_d    = valid_d && (dec.kind == ENC_WIDE) && (dec.rd == PC_REG);
    data_en  = valid_d;
  end

  // Flag registers
  always_ff @(posedge clk_i or negedge rst_n_int) begin
    if (!rst_n_int) begin
      out_valid_o   <= 1'b0;
      pc_write_o    <= 1'b0;
      unpred_o      <= 1'b0;
      decode_miss_o <= 1'b0;
    end else begin
      out_valid_o   <= valid_d;
      pc_write_o    <= pcw_d;
      unpred_o      <= unpred_d;
      decode_miss_o <= miss_d;
    end
  end

  // Data registers, clock-enabled, no reset
  always_ff @(posedge clk_i) begin
    if (data_en) begin
      result_o <= sum;
      rd_idx_o <= dec.rd;
    end
  end

endmodule

// File: rtl/pcrel_addr_unit_chk.sv
module pcrel_addr_unit_chk
  import pcrel_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             in_valid_i,
  input logic             fmt_sel_i,
  input logic [31:0]      insn_i,
  input logic [31:0]      pc_i,
  input logic             cond_pass_i,
  input logic             out_valid_o,
  input logic [31:0]      result_o,
  input logic [REG_W-1:0] rd_idx_o,
  input logic             pc_write_o,
  input logic             unpred_o,
  input logic             decode_miss_o
);

  p_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> !(out_valid_o || pc_write_o || unpred_o || decode_miss_o));

  p_cond_block_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && !cond_pass_i) |=> (!out_valid_o && !pc_write_o));

  p_pcw_dest_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_write_o |-> (out_valid_o && rd_idx_o == PC_REG));

  p_compact_no_pcw_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && fmt_sel_i) |=> !pc_write_o);

  p_excl_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({out_valid_o, decode_miss_o, unpred_o}));

  p_rsvd_cond_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && !fmt_sel_i && insn_i[31:28] == COND_RSVD) |=> decode_miss_o);

  p_zero_imm_align_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && cond_pass_i && !fmt_sel_i && insn_i[31:28] != COND_RSVD &&
     insn_i[27:16] == FIX_OP_ADD && insn_i[11:0] == 12'h000)
    |=> (out_valid_o && result_o == {$past(pc_i[31:2]), 2'b00}));

  p_sp_ok_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && fmt_sel_i && insn_i[11:8] == 4'd13) |=> !unpred_o);

endmodule

bind pcrel_addr_unit pcrel_addr_unit_chk chk_i (
  .clk_i         (clk_i),
  .rst_ni        (rst_n_int),
  .in_valid_i    (in_valid_i),
  .fmt_sel_i     (fmt_sel_i),
  .insn_i        (insn_i),
  .pc_i          (pc_i),
  .cond_pass_i   (cond_pass_i),
  .out_valid_o   (out_valid_o),
  .result_o      (result_o),
  .rd_idx_o      (rd_idx_o),
  .pc_write_o    (pc_write_o),
  .unpred_o      (unpred_o),
  .decode_miss_o (decode_miss_o)
);

// File: tb/pcrel_addr_unit_tb_top.sv
module pcrel_addr_unit_tb_top;

  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        in_valid_i, fmt_sel_i, cond_pass_i;
  logic [31:0] insn_i, pc_i;
  logic        out_valid_o, pc_write_o, unpred_o, decode_miss_o;
  logic [31:0] result_o;
  logic [3:0]  rd_idx_o;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;
  bit done     = 1'b0;

  always #5 clk_i = ~clk_i;

  pcrel_addr_unit dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .in_valid_i(in_valid_i), .fmt_sel_i(fmt_sel_i),
    .insn_i(insn_i), .pc_i(pc_i), .cond_pass_i(cond_pass_i),
    .out_valid_o(out_valid_o), .result_o(result_o), .rd_idx_o(rd_idx_o),
    .pc_write_o(pc_write_o), .unpred_o(unpred_o), .decode_miss_o(decode_miss_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] enc_fix(input logic [3:0] cnd, input bit sub,
                                          input logic [3:0] rd, input logic [11:0] imm);
    return {cnd, (sub ? 12'h24F : 12'h28F), rd, imm};
  endfunction

  function automatic logic [31:0] enc_half(input logic [2:0] rd, input logic [7:0] imm8,
                                           input logic [15:0] junk);
    return {5'b10100, rd, imm8, junk};
  endfunction

  function automatic logic [31:0] enc_pair(input bit sub, input bit i, input logic [2:0] imm3,
                                           input logic [3:0] rd, input logic [7:0] imm8);
    return {5'b11110, i, (sub ? 10'b1010101111 : 10'b1000001111), 1'b0, imm3, rd, imm8};
  endfunction

  // Independent reference: tag, flags, result, rd
  task automatic model(input bit fmt, input logic [31:0] w, input logic [31:0] pc, input bit cp,
                       output string tag, output bit e_v, output bit e_pcw, output bit e_un,
                       output bit e_miss, output logic [31:0] e_res, output logic [3:0] e_rd);
    bit hit = 0, sub = 0, wide = 0, pair = 0;
    logic [31:0] imm = 0;
    logic [63:0] dbl;
    logic [31:0] base = {pc[31:2], 2'b00};
    e_rd = 0;
    tag  = "R9";
    if (!fmt) begin
      if (w[31:28] == 4'hF) tag = "R3";
      else if (w[27:16] == 12'h28F || w[27:16] == 12'h24F) begin
        hit = 1; wide = 1; sub = (w[27:16] == 12'h24F);
        dbl = {24'd0, w[7:0], 24'd0, w[7:0]} >> (2 * w[11:8]);
        imm = dbl[31:0]; e_rd = w[15:12];
        tag = sub ? "R2" : "R1";
      end
    end else begin
      if (w[31:27] == 5'b10100) begin
        hit = 1; imm = {22'd0, w[23:16], 2'b00}; e_rd = {1'b0, w[26:24]}; tag = "R4";
      end else if (w[31:27] == 5'b11110 && !w[15] &&
                   (w[25:16] == 10'b1000001111 || w[25:16] == 10'b1010101111)) begin
        hit = 1; pair = 1; sub = (w[25:16] == 10'b1010101111);
        imm = {20'd0, w[26], w[14:12], w[7:0]}; e_rd = w[11:8]; tag = "R5";
      end else if (w[31:27] == 5'b11110) tag = "R5";
    end
    e_res  = sub ? base - imm : base + imm;
    e_miss = !hit;
    e_un   = hit && pair && e_rd == 4'd15;
    e_v    = hit && cp && !e_un;
    e_pcw  = e_v && wide && e_rd == 4'd15;
    if (e_un || e_rd == 4'd13) tag = "R7";
    if (e_pcw) tag = "R6";
    if (hit && !cp) tag = "R8";
  endtask

  task automatic run_one(input bit fmt, input logic [31:0] w, input logic [31:0] pc, input bit cp);
    string tag; bit v, pcw, un, miss; logic [31:0] res; logic [3:0] rd;
    model(fmt, w, pc, cp, tag, v, pcw, un, miss, res, rd);
    @(negedge clk_i);
    in_valid_i = 1; fmt_sel_i = fmt; insn_i = w; pc_i = pc; cond_pass_i = cp;
    @(negedge clk_i);
    in_valid_i = 0;
    chk({tag, " out_valid"}, {31'd0, out_valid_o}, {31'd0, v});
    chk({tag, " pc_write"},  {31'd0, pc_write_o},  {31'd0, pcw});
    chk({tag, " unpred"},    {31'd0, unpred_o},    {31'd0, un});
    chk({tag, " miss"},      {31'd0, decode_miss_o}, {31'd0, miss});
    if (v) begin
      chk({tag, " result"}, result_o, res);
      chk({tag, " rd"}, {28'd0, rd_idx_o}, {28'd0, rd});
    end
  endtask

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog R10 actual=%0d expected=<150000", cycles);
      $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    bit fmt, cp;
    logic [31:0] w, pc;
    int unsigned seed_dummy;
    rst_ni = 0; in_valid_i = 0; fmt_sel_i = 0; cond_pass_i = 0; insn_i = 0; pc_i = 0;
    seed_dummy = $urandom(32'h5eed_1234);
    repeat (3) @(negedge clk_i);
    // R11: flags low during reset
    chk("R11 reset flags", {28'd0, out_valid_o, pc_write_o, unpred_o, decode_miss_o}, 32'd0);
    rst_ni = 1;
    @(negedge clk_i);
    chk("R11 sync release", {28'd0, out_valid_o, pc_write_o, unpred_o, decode_miss_o}, 32'd0);
    repeat (3) @(negedge clk_i);

    // Directed corner cases
    run_one(0, enc_fix(4'hE, 0, 4'd2, 12'h000), 32'h0000_1003, 1);   // R1 align
    run_one(0, enc_fix(4'h0, 0, 4'd3, 12'h4FF), 32'h0000_0100, 1);   // R1 rotate by 8
    run_one(0, enc_fix(4'h1, 0, 4'd4, 12'hF81), 32'h0000_0000, 1);   // R1 rotate by 30
    run_one(0, enc_fix(4'hE, 1, 4'd5, 12'h010), 32'h0000_0008, 1);   // R2 wrap
    run_one(0, enc_fix(4'hE, 0, 4'd15, 12'h020), 32'h0000_4002, 1);  // R6 PC write
    run_one(0, enc_fix(4'hF, 0, 4'd1, 12'h001), 32'h0000_4000, 1);   // R3
    run_one(0, enc_fix(4'hE, 0, 4'd15, 12'h020), 32'h0000_4000, 0);  // R8
    run_one(1, enc_half(3'd7, 8'hFF, 16'hFFFF), 32'h0000_2002, 1);   // R4
    run_one(1, enc_pair(0, 1, 3'd7, 4'd13, 8'hFF), 32'h0000_0003, 1); // R5/R7 rd13
    run_one(1, enc_pair(1, 0, 3'd0, 4'd15, 8'h00), 32'h0000_1000, 1); // R7 unpred
    run_one(1, enc_pair(1, 1, 3'd2, 4'd6, 8'h10), 32'h0000_0100, 1); // R5 sub wrap
    run_one(1, enc_pair(0, 0, 3'd1, 4'd2, 8'h01) | 32'h0000_8000, 32'h100, 1); // R5 bit15
    run_one(0, 32'h1234_5678, 32'h100, 1);                            // R9
    run_one(1, 32'h0000_0000, 32'h100, 1);                            // R9
    // R10: idle cycle leaves flags low
    @(negedge clk_i);
    chk("R10 idle flags", {28'd0, out_valid_o, pc_write_o, unpred_o, decode_miss_o}, 32'd0);

    // Constrained random
    for (int n = 0; n < 3000; n++) begin
      int k;
      k  = $urandom_range(0, 4);
      pc = $urandom();
      cp = ($urandom_range(0, 7) != 0);
      case (k)
        0: begin fmt = 0; w = enc_fix(4'($urandom_range(0, 15)), bit'($urandom_range(0, 1)),
                                      4'($urandom()), 12'($urandom())); end
        1: begin fmt = 1; w = enc_half(3'($urandom()), 8'($urandom()), 16'($urandom())); end
        2: begin fmt = 1; w = enc_pair(bit'($urandom_range(0, 1)), bit'($urandom_range(0, 1)),
                                       3'($urandom()), 4'($urandom()), 8'($urandom())); end
        3: begin fmt = 1; w = enc_fix(4'hE, 0, 4'd1, 12'h0); end
        default: begin fmt = bit'($urandom_range(0, 1)); w = $urandom(); end
      endcase
      run_one(fmt, w, pc, cp);
    end

    done = 1;
    $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule